// File: doc/BRIEF.md
# Delay-Slot Fetch Address Sequencer

This block produces the fetch address for a five-stage 32-bit pipeline that uses a single branch delay slot. Each cycle it is told what kind of control-flow instruction sits at the current fetch address: none, a conditional PC-relative branch, or an absolute jump. It is also given the branch compare result, the immediate and jump-target fields, an exception request with a 5-bit cause code, and a stall. The instruction that follows any branch or jump always runs. Only after that slot does the address move to the branch or jump target, if there is one.

A raised exception takes effect precisely. The fetch address moves to a fixed vector, and a flush pulse tells the pipeline to squash younger work. The exception PC register and a cause register are written. When the faulting instruction is the delay slot of a branch or jump, the cause register's slot flag is set and the exception PC names the branch rather than the slot. Any redirect the branch had pending is dropped. A stall freezes every piece of state.

Top module: `pc_sequencer`

## Requirements
- R1: While reset is active (and on the first cycle after it), `fetchPc` equals the reset vector 0xBFC00000, `epc` and `causeReg` are zero and `flush` is low.
- R2: With no stall, no exception and no pending delay slot, a `flowKind` of 2'b00 (none) or 2'b11 (reserved, treated as none) advances `fetchPc` by 4 on the next clock.
- R3: A branch (`flowKind` 2'b01) or jump (`flowKind` 2'b10) accepted outside a delay slot always advances `fetchPc` by 4 first, so that its delay slot executes, whether the branch is taken or not.
- R4: For a branch with `cmpTaken` high, the address after the delay slot is the slot address plus the sign-extended 16-bit `imm16` shifted left by 2. With `cmpTaken` low, the address after the slot is the slot address plus 4.
- R5: For a jump, the address after the delay slot is the upper 4 bits of the slot address, then `jumpField` (26 bits), then two zero bits.
- R6: An accepted exception outside a delay slot raises `flush` in the same cycle. On the next clock `fetchPc` becomes the vector 0x80000080, `epc` becomes the faulting address, `causeReg[6:2]` becomes `excCode` and `causeReg[31]` becomes 0. All other cause bits stay 0.
- R7: An accepted exception on a delay-slot instruction sets `causeReg[31]` to 1, loads `epc` with the address of the branch or jump (4 less than the slot), and discards that branch's pending redirect.
- R8: An exception raised on the branch or jump itself cancels both its delay slot and its redirect. The instruction at the vector is followed sequentially.
- R9: While `stall` is high, `fetchPc`, `epc`, `causeReg` and any pending delay-slot state keep their values, `flush` stays low, and all other inputs, including `excReq`, are ignored.
- R10: A branch or jump presented on a delay-slot instruction is ignored. The address after it is the one decided by the earlier branch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| stall | input | 1 | Freeze all state this cycle |
| flowKind | input | 2 | Control-flow kind of the instruction at `fetchPc`: 00 none, 01 branch, 10 jump, 11 none |
| cmpTaken | input | 1 | Branch compare outcome |
| imm16 | input | 16 | Signed branch word offset |
| jumpField | input | 26 | Absolute jump word target |
| excReq | input | 1 | Instruction at `fetchPc` raises an exception |
| excCode | input | 5 | Exception cause code |
| fetchPc | output | 32 | Address of the instruction presented this cycle |
| epc | output | 32 | Exception program counter |
| causeReg | output | 32 | Cause: bit 31 slot flag, bits 6:2 code |
| flush | output | 1 | Squash younger instructions (exception accepted) |

## Verification
The properties assume that `flowKind`, `excReq` and their fields describe the instruction at the current `fetchPc`, and that they change only between clock edges. They also assume reset lasts at least one edge. The checker rebuilds delay-slot membership from the accepted branch and jump inputs alone. It relies on the slot always being the next accepted instruction, so it expects a slot-fault exception PC of exactly four below the slot. The stimulus drives every input on the falling edge. It presents exceptions both outside and inside slots, during a stall, and on a branch itself. It never leaves an input undriven or unknown.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

  typedef enum logic [1:0] {
    FLOW_NONE   = 2'b00,
    FLOW_BRANCH = 2'b01,
    FLOW_JUMP   = 2'b10,
    FLOW_RSVD   = 2'b11
  } flowKindE;

  typedef enum logic [1:0] {
    NXT_SEQ    = 2'b00,
    NXT_TARGET = 2'b01,
    NXT_VECTOR = 2'b10
  } nextSelE;

  typedef struct packed {
    logic    advance;        // update the fetch address this cycle
    logic    captureBranch;  // latch branch address and target
    logic    useJumpTarget;  // captured target comes from jump field
    nextSelE nextSel;        // source of next fetch address
    logic    raiseExc;       // write epc and cause
    logic    excInSlot;      // faulting instruction is a delay slot
  } seqStrobesT;

endpackage

// File: rtl/pcseq_ctrl.sv
module pcseq_ctrl
  import pcseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       stall,
  input  logic [1:0] flowKind,
  input  logic       cmpTaken,
  input  logic       excReq,
  output seqStrobesT strobes,
  output logic       flush
);

  logic slotQ, slotD;
  logic redirQ, redirD;
  logic isBranch, isJump, isCtl;

  assign isBranch = (flowKind == FLOW_BRANCH);
  assign isJump   = (flowKind == FLOW_JUMP);
  assign isCtl    = isBranch | isJump;

  always_comb begin
    strobes         = '0;
    strobes.nextSel = NXT_SEQ;
    slotD           = slotQ;
    redirD          = redirQ;
    if (!stall) begin
      strobes.advance = 1'b1;
      slotD           = 1'b0;
      redirD          = 1'b0;
      if (excReq) begin
        strobes.nextSel   = NXT_VECTOR;
        strobes.raiseExc  = 1'b1;
        strobes.excInSlot = slotQ;
      end else if (slotQ) begin
        // control-flow kind on a slot instruction is ignored
        strobes.nextSel = redirQ ? NXT_TARGET : NXT_SEQ;
      end else if (isCtl) begin
        strobes.captureBranch = 1'b1;
        strobes.useJumpTarget = isJump;
        slotD                 = 1'b1;
        redirD                = isJump | cmpTaken;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotQ  <= 1'b0;
      redirQ <= 1'b0;
    end else begin
      slotQ  <= slotD;
      redirQ <= redirD;
    end
  end

  assign flush = strobes.raiseExc;

endmodule

// File: rtl/pcseq_datapath.sv
module pcseq_datapath
  import pcseq_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          IMM_W     = 16,
  parameter int          JFIELD_W  = 26,
  parameter int          CODE_W    = 5,
  parameter logic [31:0] RESET_VEC = 32'hBFC0_0000,
  parameter logic [31:0] EXC_VEC   = 32'h8000_0080
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobesT          strobes,
  input  logic [IMM_W-1:0]    imm16,
  input  logic [JFIELD_W-1:0] jumpField,
  input  logic [CODE_W-1:0]   excCode,
  output logic [ADDR_W-1:0]   fetchPc,
  output logic [ADDR_W-1:0]   epc,
  output logic [ADDR_W-1:0]   causeReg
);

  localparam int WORD_SH   = 2;
  localparam int SEXT_W    = ADDR_W - IMM_W - WORD_SH;
  localparam int REGION_W  = ADDR_W - JFIELD_W - WORD_SH;
  localparam int CODE_LSB  = 2;
  localparam int CODE_MSB  = CODE_LSB + CODE_W - 1;
  localparam int SLOT_BIT  = ADDR_W - 1;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  logic [ADDR_W-1:0] pcQ, pcD;
  logic [ADDR_W-1:0] branchPcQ;
  logic [ADDR_W-1:0] targetQ;
  logic [ADDR_W-1:0] epcQ;
  logic [ADDR_W-1:0] causeQ, causeD;
  logic [ADDR_W-1:0] slotPc;
  logic [ADDR_W-1:0] relTarget, absTarget, newTarget;
  logic [ADDR_W-1:0] wordOffset;

  assign slotPc     = pcQ + STEP;
  assign wordOffset = {{SEXT_W{imm16[IMM_W-1]}}, imm16, {WORD_SH{1'b0}}};
  assign relTarget  = slotPc + wordOffset;
  assign absTarget  = {slotPc[ADDR_W-1 -: REGION_W], jumpField, {WORD_SH{1'b0}}};
  assign newTarget  = strobes.useJumpTarget ? absTarget : relTarget;

  always_comb begin
    unique case (strobes.nextSel)
      NXT_TARGET: pcD = targetQ;
      NXT_VECTOR: pcD = EXC_VEC[ADDR_W-1:0];
      default:    pcD = slotPc;
    endcase
  end

  // cause register image: slot flag on top, code field low, zeros elsewhere
  for (genvar b = 0; b < ADDR_W; b++) begin : g_cause
    if (b == SLOT_BIT) begin : g_slot
      assign causeD[b] = strobes.excInSlot;
    end else if (b >= CODE_LSB && b <= CODE_MSB) begin : g_code
      assign causeD[b] = excCode[b-CODE_LSB];
    end else begin : g_zero
      assign causeD[b] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ       <= RESET_VEC[ADDR_W-1:0];
      branchPcQ <= '0;
      targetQ   <= '0;
      epcQ      <= '0;
      causeQ    <= '0;
    end else begin
      if (strobes.advance) pcQ <= pcD;
      if (strobes.captureBranch) begin
        branchPcQ <= pcQ;
        targetQ   <= newTarget;
      end
      if (strobes.raiseExc) begin
        epcQ   <= strobes.excInSlot ? branchPcQ : pcQ;
        causeQ <= causeD;
      end
    end
  end

  assign fetchPc  = pcQ;
  assign epc      = epcQ;
  assign causeReg = causeQ;

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcseq_pkg::*;
#(
  parameter logic [31:0] RESET_VEC = 32'hBFC0_0000,
  parameter logic [31:0] EXC_VEC   = 32'h8000_0080
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        stall,
  input  logic [1:0]  flowKind,
  input  logic        cmpTaken,
  input  logic [15:0] imm16,
  input  logic [25:0] jumpField,
  input  logic        excReq,
  input  logic [4:0]  excCode,
  output logic [31:0] fetchPc,
  output logic [31:0] epc,
  output logic [31:0] causeReg,
  output logic        flush
);

  seqStrobesT strobes;

  pcseq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .stall    (stall),
    .flowKind (flowKind),
    .cmpTaken (cmpTaken),
    .excReq   (excReq),
    .strobes  (strobes),
    .flush    (flush)
  );

  pcseq_datapath #(
    .ADDR_W    (32),
    .IMM_W     (16),
    .JFIELD_W  (26),
    .CODE_W    (5),
    .RESET_VEC (RESET_VEC),
    .EXC_VEC   (EXC_VEC)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .imm16     (imm16),
    .jumpField (jumpField),
    .excCode   (excCode),
    .fetchPc   (fetchPc),
    .epc       (epc),
    .causeReg  (causeReg)
  );

endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk #(
  parameter logic [31:0] EXC_VEC = 32'h8000_0080
) (
  input logic        clk,
  input logic        rstN,
  input logic        stall,
  input logic [1:0]  flowKind,
  input logic        excReq,
  input logic [4:0]  excCode,
  input logic [31:0] fetchPc,
  input logic [31:0] epc,
  input logic [31:0] causeReg,
  input logic        flush
);

  // independent view of delay-slot membership
  logic slotSeen;
  always_ff @(posedge clk) begin
    if (!rstN) slotSeen <= 1'b0;
    else if (!stall)
      slotSeen <= !excReq && !slotSeen && (flowKind == 2'b01 || flowKind == 2'b10);
  end

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && !excReq && !slotSeen && (flowKind == 2'b00 || flowKind == 2'b11))
    |=> fetchPc == $past(fetchPc) + 32'd4);

  // R3
  slot_runs_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && !excReq && !slotSeen && (flowKind == 2'b01 || flowKind == 2'b10))
    |=> fetchPc == $past(fetchPc) + 32'd4);

  // R6
  exc_vector_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (fetchPc == EXC_VEC) && (causeReg[6:2] == $past(excCode)));

  // R6
  cause_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (causeReg[30:7] == '0) && (causeReg[1:0] == '0));

  // R7
  slot_epc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && excReq && slotSeen)
    |=> causeReg[31] && (epc == $past(fetchPc) - 32'd4));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> $stable(fetchPc) && $stable(epc) && $stable(causeReg));

  // R9
  stall_noflush_chk: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> !flush);

endmodule

bind pc_sequencer pc_sequencer_chk #(.EXC_VEC(EXC_VEC)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .stall    (stall),
  .flowKind (flowKind),
  .excReq   (excReq),
  .excCode  (excCode),
  .fetchPc  (fetchPc),
  .epc      (epc),
  .causeReg (causeReg),
  .flush    (flush)
);

// File: tb/sim_pc_sequencer.sv
module sim_pc_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int ROWS       = 18;

  typedef struct packed {
    logic        stall;
    logic [1:0]  kind;
    logic        cmp;
    logic [15:0] imm;
    logic [25:0] tgt;
    logic        exc;
    logic [4:0]  code;
    logic [31:0] expPc;
    logic        expFlush;
    logic [31:0] expEpc;
    logic [31:0] expCause;
  } vecT;

  localparam vecT VECS [ROWS] = '{
    // R2 plain step from reset vector
    '{1'b0, 2'b00, 1'b0, 16'h0000, 26'h0, 1'b0, 5'd0, 32'hBFC0_0004, 1'b0, 32'h0, 32'h0},
    // R3 taken branch still steps to its slot
    '{1'b0, 2'b01, 1'b1, 16'h0004, 26'h0, 1'b0, 5'd0, 32'hBFC0_0008, 1'b0, 32'h0, 32'h0},
    // R4 slot done, go to slot+16
    '{1'b0, 2'b00, 1'b0, 16'h0000, 26'h0, 1'b0, 5'd0, 32'hBFC0_0018, 1'b0, 32'h0, 32'h0},
    // R3 untaken branch
    '{1'b0, 2'b01, 1'b0, 16'h0010, 26'h0, 1'b0, 5'd0, 32'hBFC0_001C, 1'b0, 32'h0, 32'h0},
    // R4 untaken: sequential after slot
    '{1'b0, 2'b00, 1'b0, 16'h0000, 26'h0, 1'b0, 5'd0, 32'hBFC0_0020, 1'b0, 32'h0, 32'h0},
    // R4 backward branch, offset -4 words
    '{1'b0, 2'b01, 1'b1, 16'hFFFC, 26'h0, 1'b0, 5'd0, 32'hBFC0_0024, 1'b0, 32'h0, 32'h0},
    // R9 stall in slot with jump and exception presented: nothing moves
    '{1'b1, 2'b10, 1'b1, 16'h0000, 26'h3FF, 1'b1, 5'd12, 32'hBFC0_0024, 1'b0, 32'h0, 32'h0},
    // R9 pending redirect survived the stall
    '{1'b0, 2'b00, 1'b0, 16'h0000, 26'h0, 1'b0, 5'd0, 32'hBFC0_0014, 1'b0, 32'h0, 32'h0},
    // R5 jump steps to slot
    '{1'b0, 2'b10, 1'b0, 16'h0000, 26'h40, 1'b0, 5'd0, 32'hBFC0_0018, 1'b0, 32'h0, 32'h0},
    // R10 branch in slot ignored; R5 jump target region bits from slot
    '{1'b0, 2'b01, 1'b1, 16'h0100, 26'h0, 1'b0, 5'd0, 32'hB000_0100, 1'b0, 32'h0, 32'h0},
    // R2 reserved kind acts as none
    '{1'b0, 2'b11, 1'b1, 16'h0000, 26'h0, 1'b0, 5'd0, 32'hB000_0104, 1'b0, 32'h0, 32'h0},
    // R6 overflow-style exception outside a slot
    '{1'b0, 2'b00, 1'b0, 16'h0000, 26'h0, 1'b1, 5'd12, 32'h8000_0080, 1'b1, 32'hB000_0104, 32'h0000_0030},
    // R2 handler runs sequentially
    '{1'b0, 2'b00, 1'b0, 16'h0000, 26'h0, 1'b0, 5'd0, 32'h8000_0084, 1'b0, 32'hB000_0104, 32'h0000_0030},
    // R3 taken branch at 0x80000084
    '{1'b0, 2'b01, 1'b1, 16'h0002, 26'h0, 1'b0, 5'd0, 32'h8000_0088, 1'b0, 32'hB000_0104, 32'h0000_0030},
    // R7 syscall-style exception in slot: epc = branch, slot flag set
    '{1'b0, 2'b00, 1'b0, 16'h0000, 26'h0, 1'b1, 5'd8, 32'h8000_0080, 1'b1, 32'h8000_0084, 32'h8000_0020},
    // R7 redirect discarded: sequential, not 0x80000090
    '{1'b0, 2'b00, 1'b0, 16'h0000, 26'h0, 1'b0, 5'd0, 32'h8000_0084, 1'b0, 32'h8000_0084, 32'h8000_0020},
    // R8 exception on a jump itself
    '{1'b0, 2'b10, 1'b0, 16'h0000, 26'h3FFFFFF, 1'b1, 5'd10, 32'h8000_0080, 1'b1, 32'h8000_0084, 32'h0000_0028},
    // R8 no slot, no redirect afterwards
    '{1'b0, 2'b00, 1'b0, 16'h0000, 26'h0, 1'b0, 5'd0, 32'h8000_0084, 1'b0, 32'h8000_0084, 32'h0000_0028}
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        stall;
  logic [1:0]  flowKind;
  logic        cmpTaken;
  logic [15:0] imm16;
  logic [25:0] jumpField;
  logic        excReq;
  logic [4:0]  excCode;
  logic [31:0] fetchPc;
  logic [31:0] epc;
  logic [31:0] causeReg;
  logic        flush;

  int checks   = 0;
  int failures = 0;
  logic done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_sequencer u0 (
    .clk(clk), .rstN(rstN), .stall(stall), .flowKind(flowKind),
    .cmpTaken(cmpTaken), .imm16(imm16), .jumpField(jumpField),
    .excReq(excReq), .excCode(excCode), .fetchPc(fetchPc),
    .epc(epc), .causeReg(causeReg), .flush(flush)
  );

  task automatic check32(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic idleInputs();
    stall = 1'b0; flowKind = 2'b00; cmpTaken = 1'b0; imm16 = '0;
    jumpField = '0; excReq = 1'b0; excCode = '0;
  endtask

  task automatic checkReset(input string tag);
    check32({tag, " R1 fetchPc"}, fetchPc, 32'hBFC0_0000);
    check32({tag, " R1 epc"}, epc, 32'h0);
    check32({tag, " R1 causeReg"}, causeReg, 32'h0);
    check32({tag, " R1 flush"}, {31'b0, flush}, 32'h0);
  endtask

  initial begin
    rstN = 1'b0;
    idleInputs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkReset("initial");
    rstN = 1'b1;
    for (int i = 0; i < ROWS; i++) begin
      stall = VECS[i].stall; flowKind = VECS[i].kind; cmpTaken = VECS[i].cmp;
      imm16 = VECS[i].imm; jumpField = VECS[i].tgt;
      excReq = VECS[i].exc; excCode = VECS[i].code;
      #1;
      check32($sformatf("row %0d R6/R9 flush", i), {31'b0, flush}, {31'b0, VECS[i].expFlush});
      @(posedge clk);
      @(negedge clk);
      check32($sformatf("row %0d R2/R3/R4/R5/R10 fetchPc", i), fetchPc, VECS[i].expPc);
      check32($sformatf("row %0d R6/R7 epc", i), epc, VECS[i].expEpc);
      check32($sformatf("row %0d R6/R7 causeReg", i), causeReg, VECS[i].expCause);
    end
    // R9 exception during stall leaves epc/cause untouched
    idleInputs();
    stall = 1'b1; excReq = 1'b1; excCode = 5'd4;
    #1;
    check32("R9 flush under stall", {31'b0, flush}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    check32("R9 fetchPc under stall", fetchPc, 32'h8000_0084);
    check32("R9 causeReg under stall", causeReg, 32'h0000_0028);
    // R1 reset mid-run with a pending branch
    idleInputs();
    flowKind = 2'b01; cmpTaken = 1'b1; imm16 = 16'h0040;
    @(posedge clk);
    @(negedge clk);
    idleInputs();
    rstN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    checkReset("midrun");
    rstN = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check32("R1 no stale redirect after reset", fetchPc, 32'hBFC0_0004);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end

endmodule